// File: doc/BRIEF.md
# Power-Down Entry and Wakeup Handshake Controller

This block controls when a serial-controlled converter goes into its low-power state and how it comes out again. The command decoder flags a power-down command, which carries a mode bit. The controller then counts serial clock rising edges from the start of the frame. It commits to sleep on the eighth edge, but only if the host still holds the frame-select line low. While asleep it drives the shared data pin to a fixed level that depends on the mode. It also raises a flag that the chip uses to gate its analog circuitry.

A wake event is a level change, in either direction, on any channel that is configured as a digital input and has wakeup enabled. On such an event the controller flips the level on the data pin to tell the host. After that it ignores every further channel change until the host raises the frame-select line. Raising that line ends the low-power state and releases the pin. For test visibility the block reports the latched mode and a sticky vector that records which channels caused the wake. Both are cleared on exit.

The start, serial clock and channel inputs come from pads and are synchronized inside the block. The decoder request and the masks are already in the system clock domain.

Top module: `pwrdn_wake_ctrl`

## Requirements
- R1: After `pd_req` is seen while the frame-select line is low, `pd_active` rises in response to the 8th serial clock rising edge counted since that line fell, and not on any earlier edge.
- R2: If the frame-select line rises before that 8th edge, the pending request is dropped, and later edges in a new frame without a new request do not enter the low-power state.
- R3: While asleep in mode 0 (`pd_mode`=0) and before a wake event, `dio_oe` is 1, `dio_out` is 0 and `mode_stat` is 0.
- R4: While asleep in mode 1 (`pd_mode`=1) and before a wake event, `dio_oe` is 1, `dio_out` is 1 and `mode_stat` is 1.
- R5: A channel is eligible when its `attr_mask` bit is 0 (digital) and its `wake_en` bit is 1. Bit i of each vector belongs to channel i. A level change on an eligible channel, rising or falling against its level at entry, inverts `dio_out` and sets that channel's bit in `wake_cause`.
- R6: Changes on channels whose `attr_mask` bit is 1 (analog) or whose `wake_en` bit is 0 leave `dio_out` and `wake_cause` unchanged.
- R7: Once a wake has been signalled, further channel changes leave `dio_out` and `wake_cause` unchanged until exit.
- R8: A high frame-select line during the low-power state clears `pd_active`, `dio_oe`, `mode_stat` and `wake_cause`.
- R9: Stopping the serial clock during the low-power state does not change `pd_active` or `dio_out`.
- R10: After reset, `pd_active`, `dio_oe`, `mode_stat` and `wake_cause` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_in | input | 1 | Frame-select line from host, active low, asynchronous |
| sclk_in | input | 1 | Serial clock from host, asynchronous |
| pd_req | input | 1 | One-cycle power-down command flag from the decoder |
| pd_mode | input | 1 | Power-down mode carried with the request (0 or 1) |
| chan_in | input | N_CH | Raw digital levels of the input channels |
| attr_mask | input | N_CH | Channel type: 1 analog, 0 digital |
| wake_en | input | N_CH | Wakeup enable per channel: 1 enabled |
| pd_active | output | 1 | Low-power state flag for gating analog circuits |
| dio_out | output | 1 | Value driven onto the data pin |
| dio_oe | output | 1 | Data pin output enable |
| mode_stat | output | 1 | Latched power-down mode |
| wake_cause | output | N_CH | Sticky record of channels that triggered the wake |

## Verification
The checker assumes that `attr_mask` and `wake_en` hold steady for the whole low-power state. Under that assumption a channel marked analog can never show up in `wake_cause`. It also assumes that the frame-select line is low when the state is entered, since entry depends on a frame being open. The directed stimulus changes the masks only while the block is idle. It raises `pd_req` only after three serial edges of an open frame. It holds every pad input stable for many system clocks around each edge, so that the synchronizers settle before any output is sampled.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

    typedef enum logic [1:0] {
        PW_IDLE  = 2'd0,
        PW_ARMED = 2'd1,
        PW_SLEEP = 2'd2,
        PW_WOKEN = 2'd3
    } pw_state_e;

    // Pin level while asleep: the mode bit itself, inverted once woken.
    function automatic logic pin_level(input logic mode, input logic woken);
        return mode ^ woken;
    endfunction

    function automatic logic is_low_power(input pw_state_e st);
        return (st == PW_SLEEP) || (st == PW_WOKEN);
    endfunction

endpackage

// File: rtl/pwrdn_sync.sv
module pwrdn_sync #(
    parameter int W       = 1,
    parameter int STAGES  = 2,
    parameter bit RST_ONE = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stg[s] <= {W{RST_ONE}};
                else if (s == 0)
                    stg[s] <= d;
                else
                    stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pwrdn_frame_cnt.sv
module pwrdn_frame_cnt #(
    parameter int ENTRY_CLK = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_s,
    input  logic sclk_s,
    output logic entry_edge
);
    localparam int CW = $clog2(ENTRY_CLK + 1);
    localparam logic [CW-1:0] LAST = CW'(ENTRY_CLK - 1);
    localparam logic [CW-1:0] SAT  = CW'(ENTRY_CLK);

    logic          sclk_d;
    logic          rise;
    logic [CW-1:0] cnt;

    assign rise = sclk_s & ~sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            cnt    <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (start_s)
                cnt <= '0;
            else if (rise && cnt != SAT)
                cnt <= cnt + 1'b1;
        end
    end

    assign entry_edge = rise & ~start_s & (cnt == LAST);
endmodule

// File: rtl/pwrdn_wake_det.sv
module pwrdn_wake_det #(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            capture,
    input  logic [N_CH-1:0] chan_s,
    input  logic [N_CH-1:0] attr_mask,
    input  logic [N_CH-1:0] wake_en,
    output logic [N_CH-1:0] hits
);
    logic [N_CH-1:0] snap;
    logic [N_CH-1:0] eligible;

    always_ff @(posedge clk) begin
        if (rst)
            snap <= '0;
        else if (capture)
            snap <= chan_s;
    end

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            assign eligible[c] = ~attr_mask[c] & wake_en[c];
            assign hits[c]     = eligible[c] & (chan_s[c] ^ snap[c]);
        end
    endgenerate
endmodule

// File: rtl/pwrdn_wake_ctrl.sv
module pwrdn_wake_ctrl
    import pwrdn_pkg::*;
#(
    parameter int N_CH        = 8,
    parameter int ENTRY_CLK   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_in,
    input  logic            sclk_in,
    input  logic            pd_req,
    input  logic            pd_mode,
    input  logic [N_CH-1:0] chan_in,
    input  logic [N_CH-1:0] attr_mask,
    input  logic [N_CH-1:0] wake_en,
    output logic            pd_active,
    output logic            dio_out,
    output logic            dio_oe,
    output logic            mode_stat,
    output logic [N_CH-1:0] wake_cause
);
    logic            start_s;
    logic            sclk_s;
    logic [N_CH-1:0] chan_s;
    logic            entry_edge;
    logic [N_CH-1:0] hits;
    logic            mode_q;
    logic [N_CH-1:0] cause_q;
    pw_state_e       state;

    pwrdn_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_ONE(1'b1)) i_sync_start (
        .clk(clk), .rst(rst), .d(start_in), .q(start_s)
    );
    pwrdn_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_ONE(1'b0)) i_sync_sclk (
        .clk(clk), .rst(rst), .d(sclk_in), .q(sclk_s)
    );
    pwrdn_sync #(.W(N_CH), .STAGES(SYNC_STAGES), .RST_ONE(1'b0)) i_sync_chan (
        .clk(clk), .rst(rst), .d(chan_in), .q(chan_s)
    );

    pwrdn_frame_cnt #(.ENTRY_CLK(ENTRY_CLK)) i_frame_cnt (
        .clk(clk), .rst(rst), .start_s(start_s), .sclk_s(sclk_s),
        .entry_edge(entry_edge)
    );

    pwrdn_wake_det #(.N_CH(N_CH)) i_wake_det (
        .clk(clk), .rst(rst),
        .capture(state == PW_ARMED && entry_edge),
        .chan_s(chan_s), .attr_mask(attr_mask), .wake_en(wake_en),
        .hits(hits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PW_IDLE;
            mode_q  <= 1'b0;
            cause_q <= '0;
        end else begin
            unique case (state)
                PW_IDLE: begin
                    if (pd_req && !start_s) begin
                        state  <= PW_ARMED;
                        mode_q <= pd_mode;
                    end
                end
                PW_ARMED: begin
                    if (start_s) begin
                        state  <= PW_IDLE;
                        mode_q <= 1'b0;
                    end else if (entry_edge) begin
                        state <= PW_SLEEP;
                    end
                end
                PW_SLEEP: begin
                    if (start_s) begin
                        state  <= PW_IDLE;
                        mode_q <= 1'b0;
                    end else if (|hits) begin
                        state   <= PW_WOKEN;
                        cause_q <= hits;
                    end
                end
                PW_WOKEN: begin
                    if (start_s) begin
                        state   <= PW_IDLE;
                        mode_q  <= 1'b0;
                        cause_q <= '0;
                    end
                end
                default: state <= PW_IDLE;
            endcase
        end
    end

    assign pd_active  = is_low_power(state);
    assign dio_oe     = pd_active;
    assign dio_out    = pd_active ? pin_level(mode_q, state == PW_WOKEN) : 1'b0;
    assign mode_stat  = mode_q;
    assign wake_cause = cause_q;
endmodule

// File: rtl/pwrdn_wake_chk.sv
module pwrdn_wake_chk #(
    parameter int N_CH = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            start_s,
    input logic            pd_active,
    input logic            dio_out,
    input logic            dio_oe,
    input logic            mode_stat,
    input logic [N_CH-1:0] wake_cause,
    input logic [N_CH-1:0] attr_mask
);
    // R1: entry only happens inside an open frame
    a_r1_entry_in_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(pd_active) |-> $past(!start_s));

    // R3: mode 0 sleeps with the pin low
    a_r3_mode0_level: assert property (@(posedge clk) disable iff (rst)
        (pd_active && !mode_stat && wake_cause == '0) |-> (dio_oe && !dio_out));

    // R4: mode 1 sleeps with the pin high
    a_r4_mode1_level: assert property (@(posedge clk) disable iff (rst)
        (pd_active && mode_stat && wake_cause == '0) |-> (dio_oe && dio_out));

    // R5: once woken the pin shows the inverted mode level
    a_r5_woken_level: assert property (@(posedge clk) disable iff (rst)
        (pd_active && wake_cause != '0) |-> (dio_out == !mode_stat));

    // R6: an analog channel never appears as a wake cause
    a_r6_no_analog_cause: assert property (@(posedge clk) disable iff (rst)
        pd_active |-> ((wake_cause & attr_mask) == '0));

    // R7: the cause is frozen until exit
    a_r7_cause_locked: assert property (@(posedge clk) disable iff (rst)
        (pd_active && wake_cause != '0) |=> (!pd_active || $stable(wake_cause)));

    // R8: a high frame-select line ends the state
    a_r8_exit_on_start: assert property (@(posedge clk) disable iff (rst)
        (pd_active && start_s) |=> !pd_active);

    // R10: outside the state nothing is driven or recorded
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !pd_active |-> (!dio_oe && wake_cause == '0));
endmodule

bind pwrdn_wake_ctrl pwrdn_wake_chk #(.N_CH(N_CH)) i_pwrdn_wake_chk (
    .clk(clk), .rst(rst), .start_s(start_s), .pd_active(pd_active),
    .dio_out(dio_out), .dio_oe(dio_oe), .mode_stat(mode_stat),
    .wake_cause(wake_cause), .attr_mask(attr_mask)
);

// File: tb/test_pwrdn_wake_ctrl.sv
`timescale 1ns/1ps
module test_pwrdn_wake_ctrl;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_in = 1'b1;
    logic         sclk_in = 1'b0;
    logic         pd_req = 1'b0;
    logic         pd_mode = 1'b0;
    logic [N-1:0] chan_in = '0;
    logic [N-1:0] attr_mask = '0;
    logic [N-1:0] wake_en = '0;
    logic         pd_active, dio_out, dio_oe, mode_stat;
    logic [N-1:0] wake_cause;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pwrdn_wake_ctrl #(.N_CH(N)) i_pwrdn_wake_ctrl (
        .clk(clk), .rst(rst), .start_in(start_in), .sclk_in(sclk_in),
        .pd_req(pd_req), .pd_mode(pd_mode), .chan_in(chan_in),
        .attr_mask(attr_mask), .wake_en(wake_en), .pd_active(pd_active),
        .dio_out(dio_out), .dio_oe(dio_oe), .mode_stat(mode_stat),
        .wake_cause(wake_cause)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic sclk_pulse();
        sclk_in = 1'b1;
        wait_clks(5);
        sclk_in = 1'b0;
        wait_clks(5);
    endtask

    // Open a frame, give 3 edges, flag the request, then more edges up to total.
    task automatic open_pd_frame(input logic mode, input int total_edges);
        start_in = 1'b0;
        wait_clks(6);
        for (int i = 0; i < 3; i++) sclk_pulse();
        pd_mode = mode;
        pd_req  = 1'b1;
        wait_clks(1);
        pd_req  = 1'b0;
        for (int i = 3; i < total_edges; i++) sclk_pulse();
        wait_clks(4);
    endtask

    task automatic close_frame();
        start_in = 1'b1;
        wait_clks(6);
    endtask

    task automatic t_reset();
        check("R10 pd_active", pd_active, 0);
        check("R10 dio_oe", dio_oe, 0);
        check("R10 mode_stat", mode_stat, 0);
        check("R10 wake_cause", wake_cause, 0);
    endtask

    task automatic t_entry_mode0();
        attr_mask = '0; wake_en = '0; chan_in = '0;
        wait_clks(6);
        open_pd_frame(1'b0, 7);
        check("R1 no entry at edge 7", pd_active, 0);
        sclk_pulse();
        check("R1 entry at edge 8", pd_active, 1);
        check("R3 dio_oe", dio_oe, 1);
        check("R3 dio_out low", dio_out, 0);
        check("R3 mode_stat", mode_stat, 0);
        close_frame();
        check("R8 exit pd_active", pd_active, 0);
        check("R8 exit dio_oe", dio_oe, 0);
    endtask

    task automatic t_cancel();
        open_pd_frame(1'b0, 5);
        close_frame();
        check("R2 cancelled", pd_active, 0);
        start_in = 1'b0;
        wait_clks(6);
        for (int i = 0; i < 9; i++) sclk_pulse();
        check("R2 no entry without new request", pd_active, 0);
        close_frame();
    endtask

    task automatic t_mode1_wake();
        attr_mask = 8'h00; wake_en = 8'h10; chan_in = 8'h00;
        wait_clks(6);
        open_pd_frame(1'b1, 8);
        check("R4 asleep", pd_active, 1);
        check("R4 dio_out high", dio_out, 1);
        check("R4 mode_stat", mode_stat, 1);
        wait_clks(200);
        check("R9 still asleep with clock stopped", pd_active, 1);
        check("R9 pin unchanged", dio_out, 1);
        chan_in[4] = 1'b1;
        wait_clks(6);
        check("R5 rising change wakes", dio_out, 0);
        check("R5 cause", wake_cause, 8'h10);
        chan_in[4] = 1'b0;
        chan_in[2] = 1'b1;
        wait_clks(6);
        check("R7 pin held", dio_out, 0);
        check("R7 cause held", wake_cause, 8'h10);
        check("R7 still asleep", pd_active, 1);
        close_frame();
        check("R8 mode_stat cleared", mode_stat, 0);
        check("R8 cause cleared", wake_cause, 0);
    endtask

    task automatic t_ignore_then_fall();
        attr_mask = 8'h01; wake_en = 8'h03; chan_in = 8'h02;
        wait_clks(6);
        open_pd_frame(1'b0, 8);
        check("R3 asleep", pd_active, 1);
        chan_in[0] = 1'b1;
        chan_in[2] = 1'b1;
        wait_clks(6);
        check("R6 pin unchanged", dio_out, 0);
        check("R6 no cause", wake_cause, 0);
        chan_in[1] = 1'b0;
        wait_clks(6);
        check("R5 falling change wakes", dio_out, 1);
        check("R5 cause ch1", wake_cause, 8'h02);
        close_frame();
        check("R8 exit", pd_active, 0);
    endtask

    initial begin
        wait_clks(4);
        rst = 1'b0;
        wait_clks(2);
        t_reset();
        t_entry_mode0();
        t_cancel();
        t_mode1_wake();
        t_ignore_then_fall();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule